// File: doc/BRIEF.md
# Dataflow Operand-Triggered Issue Station

The station is the instruction window that sits in front of one ALU in a tiled dataflow core. Software places every instruction of a block on a fixed ALU and slot. The station keeps those instructions for up to eight blocks that are in flight together, with eight slots for each block, which gives 64 entries. An operand reaches a consumer by a direct write to the entry that the producer's target field names. No tag is broadcast and nothing is searched. Once an entry holds every operand its instruction needs, it becomes ready. Each cycle the station issues at most one ready entry. The issued word carries the opcode, the operands and the two target fields of the instruction, and it flags which of those targets stay on this ALU.

Operands come in on two ports. One port is the routing network. The other is a loopback from this station's own ALU, so a consumer placed on the same ALU skips the network. A block control port either refreshes a block, which clears its operands and fired marks but keeps its instructions so a loop body runs again without a refetch, or flushes it, which frees its slots. Blocks are ranked oldest first, starting from a head pointer that moves forward when the head block is flushed.

Top module: `is_station`

## Requirements
- R1: After reset no entry is loaded, `iss_valid` is low, `err` is low and the head block slot is 0.
- R2: An entry is addressed by {block[2:0], slot[2:0]}. A load writes the opcode, both target fields and the needs mask, and it clears the entry's operands and fired mark.
- R3: The needs mask has bit 0 for left, bit 1 for right and bit 2 for predicate. When the last needed operand is sampled at a clock edge, the instruction issues with `iss_valid` high from that edge on. An entry with an empty needs mask issues at the edge that loads it. At most one entry issues per cycle.
- R4: A target field is {en[9], alu[8:5], slot[4:2], sel[1:0]}. `iss_loc[k]` is high when target k has en set and alu equal to `MY_ALU`. Both fields go out unchanged on `iss_tgt0` and `iss_tgt1`.
- R5: An operand select of 0 writes the left operand, 1 writes the right operand and 2 writes the predicate (data bit 0). The stored values appear on `iss_lhs`, `iss_rhs` and `iss_pred`.
- R6: A loopback write makes its consumer issue in the cycle right after the write. When the network and the loopback write the same operand of the same entry in one cycle, the loopback value is kept.
- R7: Among ready entries the winner comes from the oldest block, counted upward modulo 8 from the head slot. Within that block the lowest instruction slot wins.
- R8: An issued entry does not issue again until it is refreshed, flushed or reloaded.
- R9: A refresh (`fl_refresh`=1) clears the operands and fired marks of the block's entries and keeps their instructions, so they issue again once their operands return.
- R10: A flush (`fl_refresh`=0) unloads every entry of the block. When the flushed block is the head, the head moves to the next block slot.
- R11: An operand sent to an unloaded entry, to a fired entry or with select 3 is dropped. It then sets `err`, which stays high until reset.
- R12: Events in the same cycle take effect in this order: block flush or refresh, then the load, then the network write, then the loopback write. The issue choice sees the result of all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Instruction load strobe |
| ld_blk | input | 3 | Block slot of the load |
| ld_slot | input | 3 | Instruction slot of the load |
| ld_needs | input | 3 | Needed operands {pred, right, left} |
| ld_opc | input | 8 | Opcode |
| ld_tgt0 | input | 10 | First target field |
| ld_tgt1 | input | 10 | Second target field |
| net_valid | input | 1 | Operand from the routing network |
| net_blk | input | 3 | Block slot of the network operand |
| net_slot | input | 3 | Instruction slot of the network operand |
| net_sel | input | 2 | Operand select |
| net_data | input | 32 | Operand value |
| loc_valid | input | 1 | Operand looped back from this ALU |
| loc_blk | input | 3 | Block slot of the loopback operand |
| loc_slot | input | 3 | Instruction slot of the loopback operand |
| loc_sel | input | 2 | Operand select |
| loc_data | input | 32 | Operand value |
| fl_valid | input | 1 | Block control strobe |
| fl_blk | input | 3 | Block slot to flush or refresh |
| fl_refresh | input | 1 | 1 refresh, 0 flush |
| iss_valid | output | 1 | An instruction issues |
| iss_blk | output | 3 | Block slot of the issued entry |
| iss_slot | output | 3 | Instruction slot of the issued entry |
| iss_opc | output | 8 | Opcode |
| iss_lhs | output | 32 | Left operand |
| iss_rhs | output | 32 | Right operand |
| iss_pred | output | 1 | Predicate |
| iss_tgt0 | output | 10 | First target field |
| iss_tgt1 | output | 10 | Second target field |
| iss_loc | output | 2 | Target k stays on this ALU |
| err | output | 1 | Sticky dropped-operand flag |

## Verification
A wrong operand-valid or fired bit shows up at the ports within one cycle of the edge that should have set it. An entry issues a cycle early, a cycle late, twice, or never, and `iss_blk` and `iss_slot` give away which entry was at fault. A wrong head pointer or priority only shows when two blocks are ready together, so the stimulus readies several entries in the same cycle, both before and after the head moves. Corrupt stored data appears on the issue operands the first time the entry fires. A reference model compares every port on every cycle, so any difference is caught at the first issue it changes.

// File: rtl/is_pkg.sv
package is_pkg;
  localparam int TG_ALU_W  = 4;
  localparam int TG_SLOT_W = 3;

  typedef enum logic [1:0] {SEL_L = 2'd0, SEL_R = 2'd1, SEL_P = 2'd2, SEL_X = 2'd3} opsel_e;

  typedef struct packed {
    logic                 en;
    logic [TG_ALU_W-1:0]  alu;
    logic [TG_SLOT_W-1:0] slot;
    logic [1:0]           sel;
  } tgt_t;

  localparam int TGT_W = $bits(tgt_t);

  // A target stays on this ALU when it is enabled and names this ALU.
  function automatic logic tgt_local(tgt_t t, logic [TG_ALU_W-1:0] me);
    return t.en && (t.alu == me);
  endfunction

  // Every operand marked as needed is present.
  function automatic logic needs_met(logic [2:0] have, logic [2:0] needs);
    return (have & needs) == needs;
  endfunction
endpackage

// File: rtl/is_pick.sv
module is_pick #(
  parameter int NB = 8,
  parameter int NS = 8,
  localparam int NE = NB * NS,
  localparam int IW = $clog2(NE),
  localparam int BW = $clog2(NB),
  localparam int SW = $clog2(NS)
) (
  input  logic [NE-1:0] req,
  input  logic [BW-1:0] head,
  output logic          gnt,
  output logic [IW-1:0] idx
);
  logic [2*NE-1:0] dbl;
  logic [NE-1:0]   rot;
  logic [IW-1:0]   off;
  logic [IW-1:0]   k;

  always_comb begin
    off = {head, {SW{1'b0}}};
    dbl = {req, req};
    rot = NE'(dbl >> off);
    gnt = |rot;
    k   = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (rot[i]) k = IW'(i);
    end
    idx = k + off;
  end
endmodule

// File: rtl/is_store.sv
module is_store
  import is_pkg::*;
#(
  parameter int NB   = 8,
  parameter int NS   = 8,
  parameter int DW   = 32,
  parameter int OPCW = 8,
  localparam int NE = NB * NS,
  localparam int IW = $clog2(NE),
  localparam int BW = $clog2(NB),
  localparam int SW = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IW-1:0]    ld_i,
  input  logic [2:0]       ld_needs,
  input  logic [OPCW-1:0]  ld_opc,
  input  logic [TGT_W-1:0] ld_tgt0,
  input  logic [TGT_W-1:0] ld_tgt1,
  input  logic             net_valid,
  input  logic [IW-1:0]    net_i,
  input  logic [1:0]       net_sel,
  input  logic [DW-1:0]    net_data,
  input  logic             loc_valid,
  input  logic [IW-1:0]    loc_i,
  input  logic [1:0]       loc_sel,
  input  logic [DW-1:0]    loc_data,
  input  logic             fl_valid,
  input  logic [BW-1:0]    fl_blk,
  input  logic             fl_refresh,
  input  logic             fire_valid,
  input  logic [IW-1:0]    fire_idx,
  output logic [NE-1:0]    ready,
  output logic             drop_net,
  output logic             drop_loc,
  output logic [OPCW-1:0]  rd_opc,
  output logic [DW-1:0]    rd_lhs,
  output logic [DW-1:0]    rd_rhs,
  output logic             rd_pred,
  output logic [TGT_W-1:0] rd_t0,
  output logic [TGT_W-1:0] rd_t1
);
  logic [NE-1:0]             loaded, fired, pred;
  logic [NE-1:0][2:0]        have, needs;
  logic [NE-1:0][OPCW-1:0]   opc;
  logic [NE-1:0][TGT_W-1:0]  t0, t1;
  logic [NE-1:0][DW-1:0]     lhs, rhs;

  logic [NE-1:0]             n_loaded, n_fired, n_pred, f_fired;
  logic [NE-1:0][2:0]        n_have, n_needs;
  logic [NE-1:0][OPCW-1:0]   n_opc;
  logic [NE-1:0][TGT_W-1:0]  n_t0, n_t1;
  logic [NE-1:0][DW-1:0]     n_lhs, n_rhs;

  // Next state in the order: block control, load, network, loopback.
  always_comb begin
    n_loaded = loaded; n_fired = fired; n_pred = pred;
    n_have = have; n_needs = needs; n_opc = opc;
    n_t0 = t0; n_t1 = t1; n_lhs = lhs; n_rhs = rhs;
    drop_net = 1'b0;
    drop_loc = 1'b0;
    if (fl_valid) begin
      for (int e = 0; e < NE; e++) begin
        if (e / NS == int'(fl_blk)) begin
          n_have[e]  = '0;
          n_fired[e] = 1'b0;
          if (!fl_refresh) n_loaded[e] = 1'b0;
        end
      end
    end
    if (ld_valid) begin
      n_loaded[ld_i] = 1'b1;
      n_fired[ld_i]  = 1'b0;
      n_have[ld_i]   = '0;
      n_needs[ld_i]  = ld_needs;
      n_opc[ld_i]    = ld_opc;
      n_t0[ld_i]     = ld_tgt0;
      n_t1[ld_i]     = ld_tgt1;
    end
    if (net_valid) begin
      if (!n_loaded[net_i] || n_fired[net_i] || net_sel == SEL_X) drop_net = 1'b1;
      else begin
        case (net_sel)
          SEL_L:   begin n_have[net_i][0] = 1'b1; n_lhs[net_i] = net_data; end
          SEL_R:   begin n_have[net_i][1] = 1'b1; n_rhs[net_i] = net_data; end
          default: begin n_have[net_i][2] = 1'b1; n_pred[net_i] = net_data[0]; end
        endcase
      end
    end
    if (loc_valid) begin
      if (!n_loaded[loc_i] || n_fired[loc_i] || loc_sel == SEL_X) drop_loc = 1'b1;
      else begin
        case (loc_sel)
          SEL_L:   begin n_have[loc_i][0] = 1'b1; n_lhs[loc_i] = loc_data; end
          SEL_R:   begin n_have[loc_i][1] = 1'b1; n_rhs[loc_i] = loc_data; end
          default: begin n_have[loc_i][2] = 1'b1; n_pred[loc_i] = loc_data[0]; end
        endcase
      end
    end
  end

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      ready[e] = n_loaded[e] && !n_fired[e] && needs_met(n_have[e], n_needs[e]);
    end
    f_fired = n_fired | (fire_valid ? (NE'(1) << fire_idx) : '0);
  end

  assign rd_opc  = n_opc[fire_idx];
  assign rd_lhs  = n_lhs[fire_idx];
  assign rd_rhs  = n_rhs[fire_idx];
  assign rd_pred = n_pred[fire_idx];
  assign rd_t0   = n_t0[fire_idx];
  assign rd_t1   = n_t1[fire_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= '0; fired <= '0; pred <= '0; have <= '0; needs <= '0;
      opc <= '0; t0 <= '0; t1 <= '0; lhs <= '0; rhs <= '0;
    end else begin
      loaded <= n_loaded; fired <= f_fired; pred <= n_pred;
      have <= n_have; needs <= n_needs; opc <= n_opc;
      t0 <= n_t0; t1 <= n_t1; lhs <= n_lhs; rhs <= n_rhs;
    end
  end
endmodule

// File: rtl/is_station.sv
module is_station
  import is_pkg::*;
#(
  parameter int NB   = 8,
  parameter int NS   = 8,
  parameter int DW   = 32,
  parameter int OPCW = 8,
  parameter logic [TG_ALU_W-1:0] MY_ALU = 4'd5,
  localparam int BW = $clog2(NB),
  localparam int SW = $clog2(NS),
  localparam int NE = NB * NS,
  localparam int IW = $clog2(NE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [BW-1:0]    ld_blk,
  input  logic [SW-1:0]    ld_slot,
  input  logic [2:0]       ld_needs,
  input  logic [OPCW-1:0]  ld_opc,
  input  logic [TGT_W-1:0] ld_tgt0,
  input  logic [TGT_W-1:0] ld_tgt1,
  input  logic             net_valid,
  input  logic [BW-1:0]    net_blk,
  input  logic [SW-1:0]    net_slot,
  input  logic [1:0]       net_sel,
  input  logic [DW-1:0]    net_data,
  input  logic             loc_valid,
  input  logic [BW-1:0]    loc_blk,
  input  logic [SW-1:0]    loc_slot,
  input  logic [1:0]       loc_sel,
  input  logic [DW-1:0]    loc_data,
  input  logic             fl_valid,
  input  logic [BW-1:0]    fl_blk,
  input  logic             fl_refresh,
  output logic             iss_valid,
  output logic [BW-1:0]    iss_blk,
  output logic [SW-1:0]    iss_slot,
  output logic [OPCW-1:0]  iss_opc,
  output logic [DW-1:0]    iss_lhs,
  output logic [DW-1:0]    iss_rhs,
  output logic             iss_pred,
  output logic [TGT_W-1:0] iss_tgt0,
  output logic [TGT_W-1:0] iss_tgt1,
  output logic [1:0]       iss_loc,
  output logic             err
);
  logic [BW-1:0]    head;
  logic [NE-1:0]    ready;
  logic             ev_fire, ev_drop, drop_net, drop_loc;
  logic [IW-1:0]    fire_idx;
  logic [OPCW-1:0]  rd_opc;
  logic [DW-1:0]    rd_lhs, rd_rhs;
  logic             rd_pred;
  logic [TGT_W-1:0] rd_t0, rd_t1;

  is_store #(.NB(NB), .NS(NS), .DW(DW), .OPCW(OPCW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_i({ld_blk, ld_slot}), .ld_needs(ld_needs),
    .ld_opc(ld_opc), .ld_tgt0(ld_tgt0), .ld_tgt1(ld_tgt1),
    .net_valid(net_valid), .net_i({net_blk, net_slot}), .net_sel(net_sel), .net_data(net_data),
    .loc_valid(loc_valid), .loc_i({loc_blk, loc_slot}), .loc_sel(loc_sel), .loc_data(loc_data),
    .fl_valid(fl_valid), .fl_blk(fl_blk), .fl_refresh(fl_refresh),
    .fire_valid(ev_fire), .fire_idx(fire_idx),
    .ready(ready), .drop_net(drop_net), .drop_loc(drop_loc),
    .rd_opc(rd_opc), .rd_lhs(rd_lhs), .rd_rhs(rd_rhs), .rd_pred(rd_pred),
    .rd_t0(rd_t0), .rd_t1(rd_t1)
  );

  is_pick #(.NB(NB), .NS(NS)) u_pick (
    .req(ready), .head(head), .gnt(ev_fire), .idx(fire_idx)
  );

  assign ev_drop = drop_net | drop_loc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; err <= 1'b0; iss_valid <= 1'b0;
      iss_blk <= '0; iss_slot <= '0; iss_opc <= '0; iss_lhs <= '0; iss_rhs <= '0;
      iss_pred <= 1'b0; iss_tgt0 <= '0; iss_tgt1 <= '0; iss_loc <= '0;
    end else begin
      err       <= err | ev_drop;
      iss_valid <= ev_fire;
      if (fl_valid && !fl_refresh && fl_blk == head) head <= head + 1'b1;
      if (ev_fire) begin
        iss_blk  <= fire_idx[IW-1:SW];
        iss_slot <= fire_idx[SW-1:0];
        iss_opc  <= rd_opc;
        iss_lhs  <= rd_lhs;
        iss_rhs  <= rd_rhs;
        iss_pred <= rd_pred;
        iss_tgt0 <= rd_t0;
        iss_tgt1 <= rd_t1;
        iss_loc  <= {tgt_local(tgt_t'(rd_t1), MY_ALU), tgt_local(tgt_t'(rd_t0), MY_ALU)};
      end
    end
  end
endmodule

// File: rtl/is_station_chk.sv
module is_station_chk #(
  parameter int NB = 8,
  parameter int NS = 8,
  localparam int NE = NB * NS,
  localparam int IW = $clog2(NE),
  localparam int BW = $clog2(NB),
  localparam int SW = $clog2(NS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_fire,
  input logic          ev_drop,
  input logic [NE-1:0] ready,
  input logic [IW-1:0] fire_idx,
  input logic          iss_valid,
  input logic [BW-1:0] iss_blk,
  input logic [SW-1:0] iss_slot,
  input logic          fl_valid,
  input logic          ld_valid,
  input logic          err
);
  p_fire_shows_r3: assert property (@(posedge clk) disable iff (!rst_n) ev_fire |=> iss_valid);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n) !ev_fire |=> !iss_valid);
  p_pick_ready_r7: assert property (@(posedge clk) disable iff (!rst_n) ev_fire |-> ready[fire_idx]);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
  p_drop_flags_r11: assert property (@(posedge clk) disable iff (!rst_n) ev_drop |=> err);
  p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && $past(iss_valid) && !$past(fl_valid) && !$past(ld_valid))
      |-> ({iss_blk, iss_slot} != $past({iss_blk, iss_slot})));
endmodule

bind is_station is_station_chk #(.NB(NB), .NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_drop(ev_drop),
  .ready(ready), .fire_idx(fire_idx), .iss_valid(iss_valid),
  .iss_blk(iss_blk), .iss_slot(iss_slot), .fl_valid(fl_valid),
  .ld_valid(ld_valid), .err(err)
);

// File: tb/tb_is_station.sv
module tb_is_station;
  localparam logic [3:0] ME = 4'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, net_valid = 0, loc_valid = 0, fl_valid = 0, fl_refresh = 0;
  logic [2:0] ld_blk = 0, ld_slot = 0, ld_needs = 0, net_blk = 0, net_slot = 0;
  logic [2:0] loc_blk = 0, loc_slot = 0, fl_blk = 0;
  logic [7:0] ld_opc = 0;
  logic [9:0] ld_tgt0 = 0, ld_tgt1 = 0;
  logic [1:0] net_sel = 0, loc_sel = 0;
  logic [31:0] net_data = 0, loc_data = 0;
  logic iss_valid, iss_pred, err;
  logic [2:0] iss_blk, iss_slot;
  logic [7:0] iss_opc;
  logic [31:0] iss_lhs, iss_rhs;
  logic [9:0] iss_tgt0, iss_tgt1;
  logic [1:0] iss_loc;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  is_station #(.MY_ALU(ME)) dut (.*);

  // Reference model
  bit m_ld[64], m_fr[64], m_p[64];
  bit [2:0] m_hv[64], m_nd[64];
  logic [7:0] m_opc[64];
  logic [9:0] m_t0[64], m_t1[64];
  logic [31:0] m_l[64], m_r[64];
  int m_head;
  bit m_err;
  bit e_v;
  int e_i;

  function automatic void m_put(int i, int sel, logic [31:0] d);
    if (!m_ld[i] || m_fr[i] || sel == 3) m_err = 1;
    else begin
      m_hv[i][sel] = 1'b1;
      if (sel == 0) m_l[i] = d;
      else if (sel == 1) m_r[i] = d;
      else m_p[i] = d[0];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_ld[i] = 0; m_fr[i] = 0; m_hv[i] = 0;
      end
      m_head = 0; m_err = 0; e_v = 0;
    end else begin
      int h0;
      h0 = m_head;
      if (fl_valid) begin
        for (int s = 0; s < 8; s++) begin
          m_hv[fl_blk*8+s] = 0; m_fr[fl_blk*8+s] = 0;
          if (!fl_refresh) m_ld[fl_blk*8+s] = 0;
        end
        if (!fl_refresh && int'(fl_blk) == m_head) m_head = (m_head + 1) % 8;
      end
      if (ld_valid) begin
        m_ld[ld_blk*8+ld_slot] = 1; m_fr[ld_blk*8+ld_slot] = 0; m_hv[ld_blk*8+ld_slot] = 0;
        m_nd[ld_blk*8+ld_slot] = ld_needs; m_opc[ld_blk*8+ld_slot] = ld_opc;
        m_t0[ld_blk*8+ld_slot] = ld_tgt0; m_t1[ld_blk*8+ld_slot] = ld_tgt1;
      end
      if (net_valid) m_put(net_blk*8+net_slot, int'(net_sel), net_data);
      if (loc_valid) m_put(loc_blk*8+loc_slot, int'(loc_sel), loc_data);
      e_v = 0;
      for (int k = 0; k < 8; k++) begin
        for (int s = 0; s < 8; s++) begin
          int i;
          i = ((h0 + k) % 8) * 8 + s;
          if (!e_v && m_ld[i] && !m_fr[i] && ((m_hv[i] & m_nd[i]) == m_nd[i])) begin
            e_v = 1; e_i = i;
          end
        end
      end
      if (e_v) m_fr[e_i] = 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    if ($time > 30) begin
      chk("R3 iss_valid per cycle", iss_valid, e_v);
      chk("R11 err per cycle", err, m_err);
      if (e_v && iss_valid) begin
        chk("R7 issued entry", {iss_blk, iss_slot}, e_i);
        chk("R5 operands", {iss_lhs, iss_rhs}, {m_l[e_i], m_r[e_i]});
        if (m_nd[e_i][2]) chk("R5 predicate", iss_pred, m_p[e_i]);
        chk("R2 opcode", iss_opc, m_opc[e_i]);
        chk("R4 targets", {iss_tgt1, iss_tgt0}, {m_t1[e_i], m_t0[e_i]});
        chk("R4 local flags", iss_loc,
            {m_t1[e_i][9] && m_t1[e_i][8:5] == ME, m_t0[e_i][9] && m_t0[e_i][8:5] == ME});
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    ld_valid = 0; net_valid = 0; loc_valid = 0; fl_valid = 0;
  endtask
  task automatic ld(int b, int s, logic [2:0] nd, logic [7:0] op, logic [9:0] a, logic [9:0] c);
    ld_valid = 1; ld_blk = 3'(b); ld_slot = 3'(s); ld_needs = nd; ld_opc = op; ld_tgt0 = a; ld_tgt1 = c;
  endtask
  task automatic net(int b, int s, int sel, logic [31:0] d);
    net_valid = 1; net_blk = 3'(b); net_slot = 3'(s); net_sel = 2'(sel); net_data = d;
  endtask
  task automatic loc(int b, int s, int sel, logic [31:0] d);
    loc_valid = 1; loc_blk = 3'(b); loc_slot = 3'(s); loc_sel = 2'(sel); loc_data = d;
  endtask
  task automatic fl(int b, bit r);
    fl_valid = 1; fl_blk = 3'(b); fl_refresh = r;
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset issue", iss_valid, 0);
    chk("R1 reset err", err, 0);
    rst_n = 1;
    // R2/R3/R4/R5: two-operand instruction, target0 local {1,5,4,L}, target1 remote
    ld(0, 3, 3'b011, 8'h21, {1'b1, 4'd5, 3'd4, 2'd0}, {1'b1, 4'd2, 3'd1, 2'd1}); tick();
    ld(0, 4, 3'b001, 8'h22, 10'd0, 10'd0); tick();
    net(0, 3, 0, 32'hA); tick();
    chk("R3 waits for right operand", iss_valid, 0);
    net(0, 3, 1, 32'hB); tick();
    chk("R3 issues after last operand", {iss_valid, iss_blk, iss_slot}, {1'b1, 3'd0, 3'd3});
    chk("R5 left/right", {iss_lhs, iss_rhs}, {32'hA, 32'hB});
    chk("R4 local flag", iss_loc, 2'b01);
    // R6 chain through loopback
    loc(0, 4, 0, 32'h15); tick();
    chk("R6 next-cycle chain", {iss_valid, iss_slot, iss_lhs}, {1'b1, 3'd4, 32'h15});
    // R8 / R11: fired entry not reissued, write dropped
    tick();
    chk("R8 no reissue", iss_valid, 0);
    net(0, 3, 0, 32'hC); tick();
    chk("R11 drop on fired", err, 1);
    chk("R8 still quiet", iss_valid, 0);
    // R7 older block wins, then lowest slot
    ld(1, 0, 3'b001, 8'h30, 10'd0, 10'd0); tick();
    ld(0, 7, 3'b001, 8'h31, 10'd0, 10'd0); tick();
    net(1, 0, 0, 32'hD); loc(0, 7, 0, 32'hE); tick();
    chk("R7 oldest block first", {iss_blk, iss_slot}, {3'd0, 3'd7});
    tick();
    chk("R7 younger block next", {iss_valid, iss_blk, iss_slot}, {1'b1, 3'd1, 3'd0});
    ld(2, 5, 3'b001, 8'h32, 10'd0, 10'd0); tick();
    ld(2, 1, 3'b001, 8'h33, 10'd0, 10'd0); tick();
    net(2, 5, 0, 32'h5); loc(2, 1, 0, 32'h1); tick();
    chk("R7 lowest slot first", iss_slot, 3'd1);
    tick();
    chk("R7 higher slot next", iss_slot, 3'd5);
    // R6 loopback wins same operand
    ld(3, 2, 3'b010, 8'h40, 10'd0, 10'd0); tick();
    net(3, 2, 1, 32'hF0); loc(3, 2, 1, 32'hF1); tick();
    chk("R6 loopback kept", iss_rhs, 32'hF1);
    // R5 predicate
    ld(3, 6, 3'b100, 8'h41, 10'd0, 10'd0); tick();
    net(3, 6, 2, 32'h1); tick();
    chk("R5 predicate issue", {iss_valid, iss_pred}, 2'b11);
    // R9 refresh keeps instructions
    fl(0, 1); tick();
    chk("R9 refresh waits for operands", iss_valid, 0);
    net(0, 3, 0, 32'hA2); loc(0, 3, 1, 32'hB2); tick();
    chk("R9 reissue after refresh", {iss_slot, iss_opc, iss_lhs, iss_rhs}, {3'd3, 8'h21, 32'hA2, 32'hB2});
    // R10 flush head block
    fl(0, 0); tick();
    net(0, 4, 0, 32'h9); tick();
    chk("R10 flushed entry dropped", iss_valid, 0);
    ld(0, 0, 3'b001, 8'h50, 10'd0, 10'd0); tick();
    ld(1, 6, 3'b001, 8'h51, 10'd0, 10'd0); tick();
    net(0, 0, 0, 32'h7); loc(1, 6, 0, 32'h8); tick();
    chk("R10 head moved to block 1", {iss_blk, iss_slot}, {3'd1, 3'd6});
    tick();
    chk("R10 block 0 now youngest", {iss_valid, iss_blk, iss_slot}, {1'b1, 3'd0, 3'd0});
    // R12 same-cycle order
    fl(2, 0); ld(2, 1, 3'b001, 8'h60, 10'd0, 10'd0); net(2, 1, 0, 32'h66); tick();
    chk("R12 flush-load-write order", {iss_valid, iss_blk, iss_slot, iss_opc, iss_lhs},
        {1'b1, 3'd2, 3'd1, 8'h60, 32'h66});
    // Reset, then select-3 drop and empty needs
    rst_n = 0; tick(); tick();
    chk("R1 err cleared", err, 0);
    rst_n = 1;
    ld(4, 0, 3'b001, 8'h70, 10'd0, 10'd0); tick();
    net(4, 0, 3, 32'h3); tick();
    chk("R11 select 3 dropped", {err, iss_valid}, 2'b10);
    ld(4, 2, 3'b000, 8'h71, 10'd0, 10'd0); tick();
    chk("R3 empty needs issues at load", {iss_valid, iss_blk, iss_slot}, {1'b1, 3'd4, 3'd2});
    fl(4, 1); tick();
    chk("R9 refresh reissues empty-needs entry", {iss_valid, iss_slot}, {1'b1, 3'd2});
    tick(); tick();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule